// File: doc/BRIEF.md
# Total-Store-Order Write Buffer with Load Forwarding

This block sits between the load/store port of a single core and a shared, single-port memory, and gives that core total-store-order semantics. Stores from the core are accepted into a small private queue and are later written to shared memory one at a time, oldest first, whenever the memory grants the port. Loads search the queue first. When a pending store matches, the load takes the data of the youngest such store. When none matches, the load goes to memory at once, ahead of any queued stores to other addresses.

Two requests order the core against other agents. A fence completes only once every queued store has reached memory. A locked exchange first waits for the queue to empty. It then reads the old word and writes the new word directly to memory, and it holds a lock signal so that the memory arbiter keeps the port for it between the read and the write. While either request is outstanding the block refuses all new requests from the core.

The core talks to the block over one request channel: a 2-bit operation code plus address and write data, with a ready/valid handshake. A response channel returns load data, the old word of an exchange, or the completion of a fence. Memory read data arrives in the cycle after a granted read.

Top module: `tso_wbuf`

## Requirements
- R1: Queued stores are written to memory strictly oldest first, one per cycle in which a write request is granted. A write request without lock is raised only while at least one store is queued.
- R2: A load (req_op = 0) whose address matches one or more queued stores is accepted at once and answered in the next cycle with the data of the youngest matching store. It does not send a read to memory.
- R3: A load with no match sends a read request in the cycle it is presented, even when stores to other addresses are still queued. It is accepted in the cycle the read is granted, and its response comes two cycles after acceptance.
- R4: A store (req_op = 1) is refused (req_ready low) while the queue holds its full 8 entries. No entry is lost.
- R5: A fence (req_op = 2) produces its response (data 0) only after every store queued before it has been written to memory.
- R6: A locked exchange (req_op = 3) begins its memory access only with an empty queue. It returns the old memory word and writes its new word straight to memory, never into the queue.
- R7: From the acceptance of a fence or exchange until its response, req_ready stays low for every operation.
- R8: After reset the queue is empty, no memory request is raised, mem_lock is low and resp_valid is low.
- R9: mem_lock stays high from the exchange's read request until its write is granted. No other memory access is granted in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_op | input | 2 | 0 load, 1 store, 2 fence, 3 locked exchange |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store data or exchange new value |
| req_ready | output | 1 | Request accepted this cycle |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_data | output | DW | Load data, exchange old value, or 0 for a fence |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Arbiter must keep the port for this agent |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rdata | input | DW | Read data, valid the cycle after a granted read |

## Verification
The collision that matters is a load that forwards from the oldest queued entry in the same cycle that this entry is being written to memory and popped. A second is a missing load that takes the memory port in the cycle a drain would otherwise use it. The first is provoked by storing with the grant enabled and loading the same address in the very next cycle. The load must return the new value after one cycle, and the memory log must show exactly one write of that value. The second is provoked by a missing load with stores still queued. It is judged by its two-cycle response latency and by the oldest-first order of the write log.

// File: rtl/tso_wbuf_pkg.sv
`timescale 1ns/1ps
package tso_wbuf_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FENCE = 2'd2,
        OP_XCHG  = 2'd3
    } wb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LDWAIT = 3'd1,
        ST_FENCE  = 3'd2,
        ST_XFLUSH = 3'd3,
        ST_XRD    = 3'd4,
        ST_XCAP   = 3'd5,
        ST_XWR    = 3'd6
    } wb_state_e;

endpackage

// File: rtl/tso_wbuf_fifo.sv
`timescale 1ns/1ps
// Circular store queue: entries exposed in full for the forwarding search.
module tso_wbuf_fifo #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [AW-1:0]                push_addr,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [PW-1:0]                head,
    output logic [CW-1:0]                count,
    output logic                         full,
    output logic                         empty,
    output logic [AW-1:0]                head_addr,
    output logic [DW-1:0]                head_data,
    output logic [DEPTH-1:0][AW-1:0]     ent_addr,
    output logic [DEPTH-1:0][DW-1:0]     ent_data
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            hd;
        logic [PW-1:0]            tl;
        logic [CW-1:0]            cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d = f_q;
        if (push) begin
            f_d.addr[f_q.tl] = push_addr;
            f_d.data[f_q.tl] = push_data;
            f_d.tl           = ptr_inc(f_q.tl);
        end
        if (pop) begin
            f_d.hd = ptr_inc(f_q.hd);
        end
        f_d.cnt = f_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign head      = f_q.hd;
    assign count     = f_q.cnt;
    assign full      = (f_q.cnt == CW'(DEPTH));
    assign empty     = (f_q.cnt == '0);
    assign head_addr = f_q.addr[f_q.hd];
    assign head_data = f_q.data[f_q.hd];
    assign ent_addr  = f_q.addr;
    assign ent_data  = f_q.data;

endmodule

// File: rtl/tso_wbuf_match.sv
`timescale 1ns/1ps
// Youngest-match search: walks entries oldest to youngest, later hits win.
module tso_wbuf_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0][AW-1:0] ent_addr,
    input  logic [DEPTH-1:0][DW-1:0] ent_data,
    input  logic [PW-1:0]            head,
    input  logic [CW-1:0]            count,
    input  logic [AW-1:0]            look_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);

    logic [PW-1:0] slot;

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        slot     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = PW'((int'(head) + k) % DEPTH);
            if ((CW'(k) < count) && (ent_addr[slot] == look_addr)) begin
                hit      = 1'b1;
                hit_data = ent_data[slot];
            end
        end
    end

endmodule

// File: rtl/tso_wbuf.sv
`timescale 1ns/1ps
module tso_wbuf
    import tso_wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          resp_valid,
    output logic [DW-1:0] resp_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_lock,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic [DW-1:0] mem_rdata
);

    typedef struct packed {
        wb_state_e     st;
        logic          rv;
        logic [DW-1:0] rd;
        logic [AW-1:0] xaddr;
        logic [DW-1:0] xdata;
        logic [DW-1:0] xold;
    } regs_t;

    regs_t r_d, r_q;

    logic                     push, pop, drain_ok;
    logic [PW-1:0]            buf_head;
    logic [CW-1:0]            buf_count;
    logic                     buf_full, buf_empty;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic                     fwd_hit;
    logic [DW-1:0]            fwd_data;
    wb_op_e                   op;
    wb_state_e                fsm_st;

    tso_wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .pop       (pop),
        .head      (buf_head),
        .count     (buf_count),
        .full      (buf_full),
        .empty     (buf_empty),
        .head_addr (head_addr),
        .head_data (head_data),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    tso_wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .head      (buf_head),
        .count     (buf_count),
        .look_addr (req_addr),
        .hit       (fwd_hit),
        .hit_data  (fwd_data)
    );

    assign op     = wb_op_e'(req_op);
    assign fsm_st = r_q.st;

    always_comb begin
        r_d       = r_q;
        r_d.rv    = 1'b0;
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_lock  = 1'b0;
        mem_addr  = head_addr;
        mem_wdata = head_data;
        push      = 1'b0;
        pop       = 1'b0;
        drain_ok  = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (op)
                        OP_LOAD: begin
                            if (fwd_hit) begin
                                req_ready = 1'b1;
                                r_d.rv    = 1'b1;
                                r_d.rd    = fwd_data;
                            end else begin
                                drain_ok  = 1'b0;
                                mem_req   = 1'b1;
                                mem_addr  = req_addr;
                                req_ready = mem_gnt;
                                if (mem_gnt) r_d.st = ST_LDWAIT;
                            end
                        end
                        OP_STORE: begin
                            req_ready = !buf_full;
                            push      = !buf_full;
                        end
                        OP_FENCE: begin
                            req_ready = 1'b1;
                            r_d.st    = ST_FENCE;
                        end
                        OP_XCHG: begin
                            req_ready = 1'b1;
                            r_d.xaddr = req_addr;
                            r_d.xdata = req_wdata;
                            r_d.st    = ST_XFLUSH;
                        end
                        default: ;
                    endcase
                end
            end
            ST_LDWAIT: begin
                r_d.rv = 1'b1;
                r_d.rd = mem_rdata;
                r_d.st = ST_IDLE;
            end
            ST_FENCE: begin
                if (buf_empty) begin
                    r_d.rv = 1'b1;
                    r_d.rd = '0;
                    r_d.st = ST_IDLE;
                end
            end
            ST_XFLUSH: begin
                if (buf_empty) r_d.st = ST_XRD;
            end
            ST_XRD: begin
                drain_ok = 1'b0;
                mem_req  = 1'b1;
                mem_lock = 1'b1;
                mem_addr = r_q.xaddr;
                if (mem_gnt) r_d.st = ST_XCAP;
            end
            ST_XCAP: begin
                drain_ok = 1'b0;
                mem_lock = 1'b1;
                r_d.xold = mem_rdata;
                r_d.st   = ST_XWR;
            end
            ST_XWR: begin
                drain_ok  = 1'b0;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_lock  = 1'b1;
                mem_addr  = r_q.xaddr;
                mem_wdata = r_q.xdata;
                if (mem_gnt) begin
                    r_d.rv = 1'b1;
                    r_d.rd = r_q.xold;
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (drain_ok && !buf_empty) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = head_addr;
            mem_wdata = head_data;
            pop       = mem_gnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign resp_valid = r_q.rv;
    assign resp_data  = r_q.rd;

endmodule

// File: rtl/tso_wbuf_chk.sv
`timescale 1ns/1ps
module tso_wbuf_chk
    import tso_wbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_op,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_lock,
    input logic          mem_gnt,
    input wb_state_e     st,
    input logic [CW-1:0] count
);

    // R4: a full queue refuses stores
    a_r4_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && req_valid && req_op == 2'd1) |-> !req_ready);

    // R7: nothing is accepted while a fence or exchange is outstanding
    a_r7_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> !req_ready);

    // R9: lock persists until the locked write is granted
    a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock && !(mem_req && mem_we && mem_gnt)) |=> mem_lock);

    // R6: locked access only with an empty queue
    a_r6_lock_empty: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock |-> (count == '0));

    // R5: fence completes with the queue empty
    a_r5_fence_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && $past(st) == ST_FENCE) |-> (count == '0));

    // R1: unlocked writes only while stores are queued
    a_r1_drain_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_lock) |-> (count != '0));

endmodule

bind tso_wbuf tso_wbuf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_lock  (mem_lock),
    .mem_gnt   (mem_gnt),
    .st        (fsm_st),
    .count     (buf_count)
);

// File: tb/tso_wbuf_tb.sv
`timescale 1ns/1ps
module tso_wbuf_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, resp_valid;
    logic [31:0] resp_data;
    logic        mem_req, mem_we, mem_lock, mem_gnt;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        gnt_en = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tso_wbuf u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    // Shared memory model: 16 words, read data one cycle after grant.
    logic [31:0] mem [16];
    logic [31:0] wlog_a [64];
    logic [31:0] wlog_d [64];
    int          wcnt = 0;
    int          pend = 0;
    int          lock_bad = 0;
    logic        in_lock = 1'b0;

    assign mem_gnt = mem_req && gnt_en;

    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                mem[mem_addr[5:2]] <= mem_wdata;
                wlog_a[wcnt] <= mem_addr;
                wlog_d[wcnt] <= mem_wdata;
                wcnt <= wcnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[5:2]];
            end
            if (!mem_lock && in_lock) lock_bad <= lock_bad + 1;
            if (mem_lock && !mem_we) in_lock <= 1'b1;
            if (mem_lock && mem_we) in_lock <= 1'b0;
        end
        if (mem_lock && pend != 0) lock_bad <= lock_bad + 1;
        pend <= pend + ((req_valid && req_ready && req_op == 2'd1) ? 1 : 0)
                     - ((mem_req && mem_gnt && mem_we && !mem_lock) ? 1 : 0);
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_resp(output logic [31:0] d, output int lat);
        lat = 0; d = '0;
        repeat (60) begin
            @(negedge clk);
            lat++;
            if (resp_valid) begin
                d = resp_data;
                break;
            end
        end
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic        gnt;
        logic [31:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [1:0]  lat;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 1'b0, 32'h4, 32'h11, 32'h0,         2'd0},
        '{2'd1, 1'b0, 32'h8, 32'h22, 32'h0,         2'd0},
        '{2'd1, 1'b0, 32'h4, 32'h33, 32'h0,         2'd0},
        '{2'd0, 1'b0, 32'h4, 32'h0,  32'h33,        2'd1},
        '{2'd0, 1'b0, 32'h8, 32'h0,  32'h22,        2'd1},
        '{2'd0, 1'b1, 32'hC, 32'h0,  32'hA000_0003, 2'd2},
        '{2'd2, 1'b1, 32'h0, 32'h0,  32'h0,         2'd0},
        '{2'd0, 1'b1, 32'h4, 32'h0,  32'h33,        2'd2},
        '{2'd3, 1'b1, 32'h8, 32'h55, 32'h22,        2'd0},
        '{2'd0, 1'b1, 32'h8, 32'h0,  32'h55,        2'd2},
        '{2'd1, 1'b1, 32'h8, 32'h66, 32'h0,         2'd0},
        '{2'd0, 1'b1, 32'h8, 32'h0,  32'h66,        2'd1},
        '{2'd0, 1'b1, 32'h8, 32'h0,  32'h66,        2'd2}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int          lat;
        int          base;
        string       tag;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset state
        @(negedge clk);
        chk(!mem_req && !mem_lock, "R8 no memory request", {30'd0, mem_req, mem_lock}, 32'h0);
        chk(!resp_valid, "R8 no response", {31'd0, resp_valid}, 32'h0);
        gnt_en = 1'b1;
        issue(2'd2, 32'h0, 32'h0);
        wait_resp(d, lat);
        chk(lat == 2 && d == 32'h0, "R8 empty fence completes", lat, 32'd2);
        chk(wcnt == 0, "R8 no writes after reset", wcnt, 32'd0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            gnt_en = VEC[i].gnt;
            issue(VEC[i].op, VEC[i].addr, VEC[i].data);
            if (VEC[i].op != 2'd1) begin
                wait_resp(d, lat);
                case (VEC[i].op)
                    2'd0:    tag = (VEC[i].lat == 2'd1) ? "R2 forward data" : "R3 memory data";
                    2'd2:    tag = "R5 fence response";
                    default: tag = "R6 exchange old value";
                endcase
                chk(d == VEC[i].exp, tag, d, VEC[i].exp);
                if (VEC[i].lat != 2'd0)
                    chk(lat == int'(VEC[i].lat), (VEC[i].lat == 2'd1) ? "R2 latency" : "R3 latency",
                        lat, 32'(VEC[i].lat));
            end
            if (i == 6) begin
                chk(wcnt == 3, "R1 drained count", wcnt, 32'd3);
                chk(wlog_a[0] == 32'h4 && wlog_d[0] == 32'h11, "R1 first write", wlog_d[0], 32'h11);
                chk(wlog_a[1] == 32'h8 && wlog_d[1] == 32'h22, "R1 second write", wlog_d[1], 32'h22);
                chk(wlog_a[2] == 32'h4 && wlog_d[2] == 32'h33, "R1 third write", wlog_d[2], 32'h33);
            end
            if (i == 8)
                chk(wcnt == 4 && wlog_a[3] == 32'h8 && wlog_d[3] == 32'h55,
                    "R6 direct exchange write", wlog_d[3], 32'h55);
            if (i == 11)
                chk(wcnt == 5 && wlog_d[4] == 32'h66, "R1 single drain during forward", wcnt, 32'd5);
        end

        // R4: full queue stalls stores
        gnt_en = 1'b0;
        base = wcnt;
        for (int k = 0; k < 8; k++) issue(2'd1, 32'h10 + 32'(4 * k), 32'h100 + 32'(k));
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 32'h30; req_wdata = 32'h1FF;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(!req_ready, "R4 full refuses store", {31'd0, req_ready}, 32'h0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        gnt_en = 1'b1;
        issue(2'd1, 32'h30, 32'h1FF);
        issue(2'd2, 32'h0, 32'h0);
        wait_resp(d, lat);
        chk(wcnt == base + 9, "R4 no store lost", wcnt, 32'(base + 9));
        for (int k = 0; k < 9; k++)
            chk(wlog_d[base + k] == ((k == 8) ? 32'h1FF : 32'h100 + 32'(k)), "R1 order after full",
                wlog_d[base + k], (k == 8) ? 32'h1FF : 32'h100 + 32'(k));

        // R7 and R5: fence holds off requests until drained
        gnt_en = 1'b0;
        issue(2'd1, 32'h20, 32'h77);
        issue(2'd2, 32'h0, 32'h0);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 32'h20;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(!req_ready, "R7 stall during fence", {31'd0, req_ready}, 32'h0);
            chk(!resp_valid, "R5 fence waits for drain", {31'd0, resp_valid}, 32'h0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        gnt_en = 1'b1;
        wait_resp(d, lat);
        chk(pend == 0 && wlog_d[wcnt - 1] == 32'h77, "R5 queue empty at fence response", pend, 32'h0);
        issue(2'd0, 32'h20, 32'h0);
        wait_resp(d, lat);
        chk(d == 32'h77, "R3 load after fence", d, 32'h77);

        // R9: lock integrity over the whole run
        chk(lock_bad == 0, "R9 lock interleave", lock_bad, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule